// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a 64-bit watchdog built around a free-running counter. The counter steps on a prescaled version of the system clock. Its value is compared with a 64-bit limit that software writes as two 32-bit words. Software sets up the block through a small word-addressed register port:

1. Select watchdog mode.
2. Choose the prescale divide.
3. Clear the count and load the limit.
4. Start the counter.
5. Write an ordered pair of 16-bit keys. This arms the watchdog.

From then on, the same key pair restarts the count from zero. If software misses a service, the count reaches the limit and the block drives a single-cycle reset request. It also records a sticky timeout flag.

Arming cannot be undone by software. Only the hardware reset clears it. While the watchdog is armed, the limit, the mode, the prescaler and the count registers ignore writes, so a runaway program cannot push the deadline back. Reading the low count word captures the high word at the same moment, so two reads give a coherent 64-bit value.

Top module: `keyed_wdt`

Register word addresses (`addr`):

| Address | Contents |
|---|---|
| 0 | Setup: mode in bits 3:2, prescale in bits 15:8 |
| 1 | Run: bits 23:22 |
| 2 | Count, low word |
| 3 | Count, high word |
| 4 | Limit, low word |
| 5 | Limit, high word |
| 6 | Key and status |
| 7 | Reads as zero |

## Requirements
- R1: After reset, every register reads zero except the prescale field in bits 15:8 of address 0, which reads 15 (divide by 16). `wd_rst` is low.
- R2: A prescale value N makes the count advance once every N+1 clocks. This holds only while the run field (bits 23:22 of address 1) equals 2.
- R3: The mode field is bits 3:2 of address 0. The key pair arms the watchdog only while the mode equals 2. With any other mode, the key pair has no effect.
- R4: At address 6, bits 31:16 carry a key and bit 14 is the enable bit. Writing key 0xA5C6 and then key 0xDA7E, each with bit 14 set, arms the watchdog and clears the count and the prescale phase.
- R5: A 0xDA7E write counts only when the write just before it to address 6 was 0xA5C6 with bit 14 set. Any other write to address 6 returns the sequence to idle.
- R6: Once armed, the enable (bit 14 of address 6) stays set until hardware reset, whatever software writes.
- R7: While armed, a count advance that finds the count equal to the limit does three things. It restarts the count at zero, pulses `wd_rst` for one cycle, and sets the sticky timeout flag in bit 15 of address 6.
- R8: While armed, writes to the limit, the setup register (mode and prescale) and the count words are ignored.
- R9: A read of the low count returns the live low word and captures the high word. A read of the high count returns the captured word.
- R10: Read data appears on `rdata` in the cycle after `rd_en` and holds until the next read.
- R11: When the watchdog is not armed, the count carries from the low word into the high word and wraps across all 64 bits, and `wd_rst` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| wd_rst | output | 1 | One-cycle watchdog reset request |

## Verification
The key sequence is driven with four patterns:
- the correct pair, repeated faster than the timeout, which must never let the reset fire;
- the second key alone, or after a foreign key;
- the first key with the enable bit clear;
- the correct pair while the mode is not watchdog.

The last three must each be rejected. The count is also started close to a 32-bit boundary and close to the 64-bit boundary. This separates the correct carry and wrap from a captured high word that would have come out stale or torn. Prescale values of 0, 1 and 3 show whether the divide is N+1.

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int          PSC_W    = 8,
  parameter int          PSC_RST  = 15,
  parameter logic [15:0] KEY_ARM  = 16'hA5C6,
  parameter logic [15:0] KEY_SVC  = 16'hDA7E
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        wd_rst
);
  localparam int DW = 32;
  localparam int CW = 2 * DW;
  localparam logic [2:0] A_SETUP = 3'd0, A_RUN = 3'd1, A_CLO = 3'd2, A_CHI = 3'd3,
                         A_PLO = 3'd4, A_PHI = 3'd5, A_KEY = 3'd6;
  localparam logic [1:0] MODE_WD = 2'd2, RUN_CONT = 2'd2;

  logic [1:0]       mode, run;
  logic [PSC_W-1:0] psc_div, psc_cnt;
  logic [CW-1:0]    cnt, per;
  logic [DW-1:0]    hi_snap, rd_mux;
  logic             wd_en, wd_to, key_stage;

  wire wr_key  = wr_en && addr == A_KEY;
  wire key_arm = wr_key && wdata[14] && wdata[31:16] == KEY_ARM;
  wire key_svc = wr_key && wdata[14] && wdata[31:16] == KEY_SVC && key_stage && mode == MODE_WD;
  wire running = run == RUN_CONT;
  wire tick    = running && psc_cnt == psc_div;
  wire expire  = tick && wd_en && cnt == per;
  wire open_wr = wr_en && !wd_en;

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_SETUP: begin rd_mux[8 +: PSC_W] = psc_div; rd_mux[3:2] = mode; end
      A_RUN:   rd_mux[23:22] = run;
      A_CLO:   rd_mux = cnt[DW-1:0];
      A_CHI:   rd_mux = hi_snap;
      A_PLO:   rd_mux = per[DW-1:0];
      A_PHI:   rd_mux = per[CW-1:DW];
      A_KEY:   begin rd_mux[15] = wd_to; rd_mux[14] = wd_en; end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= '0; run <= '0; psc_div <= PSC_W'(PSC_RST); psc_cnt <= '0;
      cnt <= '0; per <= '0; hi_snap <= '0; rdata <= '0;
      wd_en <= 1'b0; wd_to <= 1'b0; key_stage <= 1'b0; wd_rst <= 1'b0;
    end else begin
      wd_rst <= 1'b0;
      if (wr_key) key_stage <= key_arm;
      if (key_svc) wd_en <= 1'b1;

      if (key_svc)      psc_cnt <= '0;
      else if (running) psc_cnt <= tick ? '0 : psc_cnt + 1'b1;

      if (key_svc)                      cnt <= '0;
      else if (open_wr && addr == A_CLO) cnt[DW-1:0] <= wdata;
      else if (open_wr && addr == A_CHI) cnt[CW-1:DW] <= wdata;
      else if (expire) begin
        cnt    <= '0;
        wd_rst <= 1'b1;
        wd_to  <= 1'b1;
      end else if (tick) cnt <= cnt + 1'b1;

      if (open_wr && addr == A_SETUP) begin
        mode    <= wdata[3:2];
        psc_div <= wdata[8 +: PSC_W];
      end
      if (wr_en && addr == A_RUN)   run <= wdata[23:22];
      if (open_wr && addr == A_PLO) per[DW-1:0] <= wdata;
      if (open_wr && addr == A_PHI) per[CW-1:DW] <= wdata;

      if (rd_en) begin
        rdata <= rd_mux;
        if (addr == A_CLO) hi_snap <= cnt[CW-1:DW];
      end
    end
  end

  a_r6_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n) wd_en |=> wd_en);
  a_r7_flag_sticky:   assert property (@(posedge clk) disable iff (!rst_n) wd_to |=> wd_to);
  a_r7_pulse_flags:   assert property (@(posedge clk) disable iff (!rst_n) wd_rst |-> wd_to && cnt == '0);
  a_r8_limit_locked:  assert property (@(posedge clk) disable iff (!rst_n) wd_en |=> $stable(per) && $stable(mode));
  a_r11_no_rst_idle:  assert property (@(posedge clk) disable iff (!rst_n) !wd_en |=> !wd_rst);
  a_r4_arm_clears:    assert property (@(posedge clk) disable iff (!rst_n) $rose(wd_en) |-> cnt == '0);
endmodule

// File: tb/keyed_wdt_tb.sv
module keyed_wdt_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, wd_rst;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  int compared = 0, mismatched = 0, pulses = 0;
  string phase = "R1";

  keyed_wdt u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
                   .addr(addr), .wdata(wdata), .rdata(rdata), .wd_rst(wd_rst));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  logic [1:0] m_mode, m_run; logic [7:0] m_div, m_pc;
  logic [63:0] m_cnt, m_per; logic [31:0] m_snap, m_rdata;
  logic m_en, m_to, m_stage, m_rst;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_run = 0; m_div = 15; m_pc = 0; m_cnt = 0; m_per = 0;
      m_snap = 0; m_rdata = 0; m_en = 0; m_to = 0; m_stage = 0; m_rst = 0;
    end else begin
      logic step, hit, svc, kw, free;
      kw   = wr_en && addr == 3'd6;
      svc  = kw && wdata[14] && wdata[31:16] == 16'hDA7E && m_stage && m_mode == 2;
      step = (m_run == 2) && (m_pc == m_div);
      hit  = step && m_en && (m_cnt == m_per);
      free = wr_en && !m_en;
      if (rd_en) begin
        case (addr)
          3'd0: m_rdata = {16'h0, m_div, 4'h0, m_mode, 2'b00};
          3'd1: m_rdata = {8'h0, m_run, 22'h0};
          3'd2: begin m_rdata = m_cnt[31:0]; m_snap = m_cnt[63:32]; end
          3'd3: m_rdata = m_snap;
          3'd4: m_rdata = m_per[31:0];
          3'd5: m_rdata = m_per[63:32];
          3'd6: m_rdata = {16'h0, m_to, m_en, 14'h0};
          default: m_rdata = 0;
        endcase
      end
      m_rst = 0;
      if (svc) m_cnt = 0;
      else if (free && addr == 3'd2) m_cnt[31:0] = wdata;
      else if (free && addr == 3'd3) m_cnt[63:32] = wdata;
      else if (hit) begin m_cnt = 0; m_rst = 1; m_to = 1; end
      else if (step) m_cnt = m_cnt + 1;
      if (svc) m_pc = 0; else if (m_run == 2) m_pc = step ? 8'd0 : m_pc + 8'd1;
      if (svc) m_en = 1;
      if (kw) m_stage = wdata[14] && wdata[31:16] == 16'hA5C6;
      if (free && addr == 3'd0) begin m_mode = wdata[3:2]; m_div = wdata[15:8]; end
      if (wr_en && addr == 3'd1) m_run = wdata[23:22];
      if (free && addr == 3'd4) m_per[31:0] = wdata;
      if (free && addr == 3'd5) m_per[63:32] = wdata;
    end
  end

  always @(negedge clk) if (rst_n) begin
    compared++;
    if (rdata !== m_rdata || wd_rst !== m_rst) begin
      mismatched++;
      $display("FAIL %s cycle compare: rdata=%h wd_rst=%b expected rdata=%h wd_rst=%b",
               phase, rdata, wd_rst, m_rdata, m_rst);
    end
    if (wd_rst) pulses++;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; v = rdata;
  endtask

  task automatic service();
    wr(3'd6, 32'hA5C6_4000); wr(3'd6, 32'hDA7E_4000);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    logic [31:0] v, lo, hi;
    repeat (3) @(negedge clk); rst_n = 1;
    phase = "R1";
    rd(3'd0, v); check("R1 setup reset", v, 32'h0000_0F00);
    rd(3'd6, v); check("R1 key reset", v, 32'h0);
    check("R1 wd_rst low", {31'h0, wd_rst}, 32'h0);

    phase = "R4";
    wr(3'd0, 32'h0000_0108);
    wr(3'd2, 0); wr(3'd3, 0); wr(3'd4, 20); wr(3'd5, 0);
    wr(3'd1, 32'h0080_0000);
    service();
    rd(3'd6, v); check("R4 armed", v, 32'h0000_4000);
    pulses = 0;
    for (int i = 0; i < 5; i++) begin repeat (20) @(negedge clk); service(); end
    check("R4 serviced no reset", pulses, 0);

    phase = "R5";
    pulses = 0;
    wr(3'd6, 32'hA5C6_4000); wr(3'd6, 32'h1234_4000); wr(3'd6, 32'hDA7E_4000);
    wr(3'd6, 32'hA5C6_0000); wr(3'd6, 32'hDA7E_4000);
    repeat (50) @(negedge clk);
    check("R5 broken sequence lets R7 timeout fire once", pulses, 1);
    phase = "R7";
    rd(3'd6, v); check("R7 timeout flag", v, 32'h0000_C000);

    phase = "R8";
    wr(3'd4, 5); rd(3'd4, v); check("R8 limit locked", v, 20);
    wr(3'd0, 0); rd(3'd0, v); check("R8 setup locked", v, 32'h0000_0108);
    phase = "R6";
    wr(3'd6, 0); rd(3'd6, v); check("R6 enable sticky", v[14], 1);

    @(negedge clk); rst_n = 0; repeat (3) @(negedge clk); rst_n = 1;
    phase = "R3";
    wr(3'd0, 0); wr(3'd3, 5); wr(3'd2, 32'hFFFF_FFF0); wr(3'd1, 32'h0080_0000);
    service();
    rd(3'd6, v); check("R3 no arm outside mode 2", v, 0);
    pulses = 0;
    repeat (30) @(negedge clk);
    phase = "R9";
    rd(3'd2, lo); rd(3'd3, hi); check("R11 carry to high word", hi, 6);
    wr(3'd2, 32'hFFFF_FFFE);
    rd(3'd2, lo); rd(3'd3, hi);
    check("R9 low near top", {31'h0, lo > 32'hFFFF_0000}, 1);
    check("R9 high word captured", hi, 6);
    rd(3'd2, lo); rd(3'd3, hi); check("R9 fresh capture", hi, 7);
    phase = "R11";
    wr(3'd3, 32'hFFFF_FFFF); wr(3'd2, 32'hFFFF_FFF0);
    repeat (30) @(negedge clk);
    rd(3'd2, lo); rd(3'd3, hi); check("R11 64-bit wrap", hi, 0);
    check("R11 no reset while disarmed", pulses, 0);

    phase = "R2";
    wr(3'd1, 0); wr(3'd2, 0); wr(3'd3, 0); wr(3'd0, 32'h0000_0300);
    wr(3'd1, 32'h0080_0000);
    repeat (40) @(negedge clk);
    wr(3'd1, 0);
    rd(3'd2, v); check("R2 divide by four", {31'h0, v >= 9 && v <= 11}, 1);
    phase = "R10";
    repeat (3) @(negedge clk);
    check("R10 read data held", rdata, v);
    summary();
  end
endmodule